// File: doc/BRIEF.md
# Host Output Buffer Arbiter with Interrupt Generation

This block sits between a keyboard-style peripheral controller's data sources and the host's data port. Four producers can have a byte waiting: the controller itself (a one-byte reply loaded by the command decoder, tagged either for the keyboard channel or for the auxiliary channel), the keyboard device interface and the auxiliary device interface. The block picks one of them by fixed priority, holds it in the single host-visible output buffer, raises the output-full and aux-output-full flags, and drives the keyboard and auxiliary interrupt lines from those flags and the mode byte.

A host read of the data port while the buffer is full returns the held byte, clears both flags and sends a one-cycle pop strobe to the device interface that supplied the byte. An optional hold-off timer, enabled by a static input, keeps the buffer empty for a programmable number of cycles after each keyboard-device byte is read, so keyboard bytes reach the host spaced apart. A read while the buffer is empty returns the byte returned by the last read.

The state machine has three states: `ST_EMPTY` (waiting for an eligible source), `ST_FULL` (a byte is held) and `ST_HOLD` (hold-off timer running). Transitions: `ST_EMPTY -> ST_FULL` when a source is eligible and the timer is idle; `ST_FULL -> ST_HOLD` on a read of a keyboard-device byte with the hold-off enabled; `ST_FULL -> ST_EMPTY` on any other read; `ST_HOLD -> ST_EMPTY` when the timer expires.

Top module: `obuf_arbiter`

## Requirements
- R1: After reset the output-full and aux-output-full flags, both interrupt lines, both pop strobes and the mirror bits are 0, and a data read returns 0x00.
- R2: When several sources are eligible while the buffer is empty, the selection order is controller reply tagged keyboard, then controller reply tagged aux, then keyboard device, then aux device; the reply register holds a single tag, so a controller reply of either tag beats both devices.
- R3: The keyboard device is ineligible while mode bit 4 is 1 and the aux device while mode bit 5 is 1; clearing the bit makes a waiting device eligible at once.
- R4: One cycle after a source is selected, output-full is 1; aux-output-full is 1 only for the aux-tagged reply and the aux device. Mirror output bit 0 equals output-full and bit 1 equals aux-output-full (they sit at output-port bits 4 and 5).
- R5: The keyboard interrupt is 1 exactly when output-full is 1, aux-output-full is 0, mode bit 0 is 1 and mode bit 4 is 0, tracking the mode input in the same cycle.
- R6: The aux interrupt is 1 exactly when both full flags are 1 and mode bit 1 is 1.
- R7: While output-full is 1 and no read occurs, the held byte and both flags do not change, even when a higher-priority source becomes pending.
- R8: A read while output-full is 1 returns the held byte, pulses the matching device pop strobe in that same cycle (none for a controller reply), and both flags are 0 in the next cycle.
- R9: A read while output-full is 0 returns the byte of the previous read and pulses no pop strobe.
- R10: Writing a reply replaces the reply byte and clears both reply tags before setting only the new one; the old tag is not served afterwards.
- R11: With the hold-off enabled, after a keyboard-device byte is read no source is selected for THROTTLE_CYCLES cycles, and selection resumes within four cycles after that; with it disabled, or after an aux byte is read, a waiting source is selected in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| throttle_en_i | input | 1 | Static enable of the keyboard hold-off timer |
| mode_i | input | 8 | Mode byte: bit 0 kbd irq enable, bit 1 aux irq enable, bit 4 kbd disable, bit 5 aux disable |
| kbd_pend_i | input | 1 | Keyboard device has a byte waiting |
| kbd_byte_i | input | 8 | Keyboard device head byte |
| aux_pend_i | input | 1 | Aux device has a byte waiting |
| aux_byte_i | input | 8 | Aux device head byte |
| reply_wr_i | input | 1 | Load a controller reply |
| reply_aux_i | input | 1 | Tag of the reply: 1 aux, 0 keyboard |
| reply_byte_i | input | 8 | Reply byte |
| rd_i | input | 1 | Host data-port read strobe |
| rd_data_o | output | 8 | Byte returned by the read |
| obf_o | output | 1 | Output-full flag |
| aux_obf_o | output | 1 | Aux-output-full flag |
| port_mirror_o | output | 2 | Flag copies for output-port bits 5:4 ({aux-full, full}) |
| kbd_pop_o | output | 1 | Keyboard byte consumed strobe |
| aux_pop_o | output | 1 | Aux byte consumed strobe |
| irq_kbd_o | output | 1 | Keyboard interrupt level |
| irq_aux_o | output | 1 | Aux interrupt level |

## Verification
Selection is tried with all sources pending at once behind masks that are then lifted one by one, which separates the fixed order from arrival order and shows that the mode disable bits gate eligibility. Replies written while a device byte is held show both the no-reselection rule and the tag overwrite, since only the last tag may surface after the read. Reads of keyboard bytes with the hold-off on and off, and of aux bytes, tell apart a timer that spaces only keyboard traffic from one that stalls everything; interrupt levels are swept over mode values while keyboard and aux bytes are held.

// File: rtl/obuf_pkg.sv
package obuf_pkg;
    localparam int DW         = 8;
    localparam int NUM_SRC    = 4;
    localparam int MODE_KIRQ  = 0;
    localparam int MODE_AIRQ  = 1;
    localparam int MODE_KDIS  = 4;
    localparam int MODE_ADIS  = 5;

    // index order is the priority order (lowest index wins)
    typedef enum logic [1:0] {
        SRC_CTRL_KBD = 2'd0,
        SRC_CTRL_AUX = 2'd1,
        SRC_KBD_DEV  = 2'd2,
        SRC_AUX_DEV  = 2'd3
    } src_e;

    typedef enum logic [1:0] {
        ST_EMPTY = 2'd0,
        ST_FULL  = 2'd1,
        ST_HOLD  = 2'd2
    } state_e;
endpackage

// File: rtl/obuf_prio_sel.sv
module obuf_prio_sel
    import obuf_pkg::*;
(
    input  logic [NUM_SRC-1:0] req_i,
    output logic               any_o,
    output src_e               sel_o
);
    always_comb begin
        sel_o = SRC_AUX_DEV;
        for (int i = NUM_SRC - 1; i >= 0; i--) begin
            if (req_i[i]) begin
                sel_o = src_e'(i[1:0]);
            end
        end
    end

    assign any_o = |req_i;
endmodule

// File: rtl/obuf_reply_reg.sv
module obuf_reply_reg
    import obuf_pkg::*;
(
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_i,
    input  logic          aux_i,
    input  logic [DW-1:0] byte_i,
    input  logic          consume_i,
    output logic [DW-1:0] byte_o,
    output logic [1:0]    pend_o   // [0] keyboard tag, [1] aux tag
);
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            byte_o <= '0;
            pend_o <= '0;
        end else if (wr_i) begin
            byte_o <= byte_i;
            pend_o <= aux_i ? 2'b10 : 2'b01;
        end else if (consume_i) begin
            pend_o <= '0;
        end
    end
endmodule

// File: rtl/obuf_throttle.sv
module obuf_throttle #(
    parameter int CYCLES = 200000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start_i,
    output logic running_o
);
    localparam int CW = $clog2(CYCLES + 1);
    localparam logic [CW-1:0] LOAD = CW'(CYCLES);

    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (start_i) begin
            cnt_q <= LOAD;
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign running_o = (cnt_q != '0);
endmodule

// File: rtl/obuf_arbiter.sv
module obuf_arbiter
    import obuf_pkg::*;
#(
    parameter int THROTTLE_CYCLES = 200000
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          throttle_en_i,
    input  logic [7:0]    mode_i,
    input  logic          kbd_pend_i,
    input  logic [DW-1:0] kbd_byte_i,
    input  logic          aux_pend_i,
    input  logic [DW-1:0] aux_byte_i,
    input  logic          reply_wr_i,
    input  logic          reply_aux_i,
    input  logic [DW-1:0] reply_byte_i,
    input  logic          rd_i,
    output logic [DW-1:0] rd_data_o,
    output logic          obf_o,
    output logic          aux_obf_o,
    output logic [1:0]    port_mirror_o,
    output logic          kbd_pop_o,
    output logic          aux_pop_o,
    output logic          irq_kbd_o,
    output logic          irq_aux_o
);
    state_e        state_q, state_d;
    src_e          src_q, src_d;
    src_e          sel;
    logic          req_any;
    logic [NUM_SRC-1:0] req;
    logic [DW-1:0] last_q, cur_byte;
    logic [DW-1:0] reply_byte;
    logic [1:0]    reply_pend;
    logic          reply_consume;
    logic          thr_start, thr_running;
    logic          rd_full;
    logic          unused_mode;

    assign unused_mode = ^{mode_i[7:6], mode_i[3:2]};

    obuf_reply_reg u_reply (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_i      (reply_wr_i),
        .aux_i     (reply_aux_i),
        .byte_i    (reply_byte_i),
        .consume_i (reply_consume),
        .byte_o    (reply_byte),
        .pend_o    (reply_pend)
    );

    // eligible sources, already in priority order
    assign req = {aux_pend_i & ~mode_i[MODE_ADIS],
                  kbd_pend_i & ~mode_i[MODE_KDIS],
                  reply_pend[1],
                  reply_pend[0]};

    obuf_prio_sel u_sel (
        .req_i (req),
        .any_o (req_any),
        .sel_o (sel)
    );

    obuf_throttle #(.CYCLES(THROTTLE_CYCLES)) u_thr (
        .clk       (clk),
        .rst_n     (rst_n),
        .start_i   (thr_start),
        .running_o (thr_running)
    );

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_EMPTY;
            src_q   <= SRC_CTRL_KBD;
            last_q  <= '0;
        end else begin
            state_q <= state_d;
            src_q   <= src_d;
            if (rd_full) begin
                last_q <= cur_byte;
            end
        end
    end

    // next state
    always_comb begin
        state_d   = state_q;
        src_d     = src_q;
        thr_start = 1'b0;
        unique case (state_q)
            ST_EMPTY: begin
                if (req_any && !thr_running) begin
                    state_d = ST_FULL;
                    src_d   = sel;
                end
            end
            ST_FULL: begin
                if (rd_i) begin
                    if (src_q == SRC_KBD_DEV && throttle_en_i) begin
                        state_d   = ST_HOLD;
                        thr_start = 1'b1;
                    end else begin
                        state_d = ST_EMPTY;
                    end
                end
            end
            ST_HOLD: begin
                if (!thr_running) begin
                    state_d = ST_EMPTY;
                end
            end
            default: state_d = ST_EMPTY;
        endcase
    end

    // outputs
    always_comb begin
        obf_o     = (state_q == ST_FULL);
        aux_obf_o = obf_o && (src_q == SRC_CTRL_AUX || src_q == SRC_AUX_DEV);
        rd_full   = rd_i && obf_o;
        unique case (src_q)
            SRC_KBD_DEV: cur_byte = kbd_byte_i;
            SRC_AUX_DEV: cur_byte = aux_byte_i;
            default:     cur_byte = reply_byte;
        endcase
        rd_data_o     = obf_o ? cur_byte : last_q;
        kbd_pop_o     = rd_full && (src_q == SRC_KBD_DEV);
        aux_pop_o     = rd_full && (src_q == SRC_AUX_DEV);
        reply_consume = rd_full && (src_q == SRC_CTRL_KBD || src_q == SRC_CTRL_AUX);
        port_mirror_o = {aux_obf_o, obf_o};
        irq_kbd_o     = obf_o && !aux_obf_o && mode_i[MODE_KIRQ] && !mode_i[MODE_KDIS];
        irq_aux_o     = aux_obf_o && mode_i[MODE_AIRQ];
    end
endmodule

// File: rtl/obuf_arbiter_chk.sv
module obuf_arbiter_chk (
    input logic       clk,
    input logic       rst_n,
    input logic [7:0] mode_i,
    input logic       rd_i,
    input logic       obf_o,
    input logic       aux_obf_o,
    input logic       irq_kbd_o,
    input logic       irq_aux_o,
    input logic       kbd_pop_o,
    input logic       aux_pop_o
);
    logic unused_mode;
    assign unused_mode = ^{mode_i[7:6], mode_i[5], mode_i[3:2]};

    a_r4_aux_needs_full: assert property (@(posedge clk) disable iff (!rst_n)
        aux_obf_o |-> obf_o);

    a_r5_kbd_irq_gate: assert property (@(posedge clk) disable iff (!rst_n)
        irq_kbd_o |-> (obf_o && !aux_obf_o && mode_i[0] && !mode_i[4]));

    a_r6_aux_irq_gate: assert property (@(posedge clk) disable iff (!rst_n)
        irq_aux_o |-> (aux_obf_o && mode_i[1]));

    a_r7_hold_full: assert property (@(posedge clk) disable iff (!rst_n)
        (obf_o && !rd_i) |=> (obf_o && $stable(aux_obf_o)));

    a_r8_read_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (obf_o && rd_i) |=> !obf_o);

    a_r8_pop_needs_read: assert property (@(posedge clk) disable iff (!rst_n)
        (kbd_pop_o || aux_pop_o) |-> (rd_i && obf_o));

    a_r8_pop_single: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({kbd_pop_o, aux_pop_o}));

    a_r4_aux_pop_flag: assert property (@(posedge clk) disable iff (!rst_n)
        aux_pop_o |-> aux_obf_o);
endmodule

bind obuf_arbiter obuf_arbiter_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .mode_i    (mode_i),
    .rd_i      (rd_i),
    .obf_o     (obf_o),
    .aux_obf_o (aux_obf_o),
    .irq_kbd_o (irq_kbd_o),
    .irq_aux_o (irq_aux_o),
    .kbd_pop_o (kbd_pop_o),
    .aux_pop_o (aux_pop_o)
);

// File: tb/obuf_arbiter_test.sv
`timescale 1ns/1ps
module obuf_arbiter_test;
    localparam int THR = 20;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       throttle_en = 1'b0;
    logic [7:0] mode = 8'h03;
    logic       kbd_pend = 1'b0, aux_pend = 1'b0;
    logic [7:0] kbd_byte = 8'h00, aux_byte = 8'h00;
    logic       reply_wr = 1'b0, reply_aux = 1'b0;
    logic [7:0] reply_byte = 8'h00;
    logic       rd = 1'b0;
    logic [7:0] rd_data;
    logic       obf, aux_obf, kbd_pop, aux_pop, irq_kbd, irq_aux;
    logic [1:0] mirror;

    int checks = 0;
    int errors = 0;

    always #2.5 clk = ~clk;

    obuf_arbiter #(.THROTTLE_CYCLES(THR)) uut (
        .clk(clk), .rst_n(rst_n), .throttle_en_i(throttle_en), .mode_i(mode),
        .kbd_pend_i(kbd_pend), .kbd_byte_i(kbd_byte),
        .aux_pend_i(aux_pend), .aux_byte_i(aux_byte),
        .reply_wr_i(reply_wr), .reply_aux_i(reply_aux), .reply_byte_i(reply_byte),
        .rd_i(rd), .rd_data_o(rd_data), .obf_o(obf), .aux_obf_o(aux_obf),
        .port_mirror_o(mirror), .kbd_pop_o(kbd_pop), .aux_pop_o(aux_pop),
        .irq_kbd_o(irq_kbd), .irq_aux_o(irq_aux)
    );

    // device model: a pop consumes the waiting byte
    always @(posedge clk) begin
        if (kbd_pop) kbd_pend <= 1'b0;
        if (aux_pop) aux_pend <= 1'b0;
    end

    task automatic chk(input string req, input logic [7:0] got, input logic [7:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s: got %02h expected %02h", req, got, exp);
        end
    endtask

    task automatic tick(input int n = 1);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic post_kbd(input logic [7:0] b);
        kbd_byte = b; kbd_pend = 1'b1;
    endtask

    task automatic post_aux(input logic [7:0] b);
        aux_byte = b; aux_pend = 1'b1;
    endtask

    task automatic write_reply(input logic tag_aux, input logic [7:0] b);
        reply_wr = 1'b1; reply_aux = tag_aux; reply_byte = b;
        tick();
        reply_wr = 1'b0;
    endtask

    // read at a falling edge; returns byte and pop strobes of that cycle
    task automatic host_read(output logic [7:0] d, output logic kp, output logic ap);
        rd = 1'b1;
        #1;
        d = rd_data; kp = kbd_pop; ap = aux_pop;
        tick();
        rd = 1'b0;
    endtask

    task automatic t_reset();
        logic [7:0] d; logic kp, ap;
        chk("R1 obf", {7'd0, obf}, 8'h00);
        chk("R1 aux_obf", {7'd0, aux_obf}, 8'h00);
        chk("R1 irqs", {6'd0, irq_kbd, irq_aux}, 8'h00);
        chk("R1 mirror", {6'd0, mirror}, 8'h00);
        host_read(d, kp, ap);
        chk("R1 read data", d, 8'h00);
        chk("R1 pops", {6'd0, kp, ap}, 8'h00);
    endtask

    task automatic t_priority();
        logic [7:0] d; logic kp, ap;
        mode = 8'h33;
        post_kbd(8'h4B); post_aux(8'hA1);
        write_reply(1'b1, 8'hC5);
        tick();
        chk("R2 reply first flags", {6'd0, aux_obf, obf}, 8'h03);
        chk("R4 mirror aux reply", {6'd0, mirror}, 8'h03);
        host_read(d, kp, ap);
        chk("R2 reply byte", d, 8'hC5);
        chk("R8 reply no pop", {6'd0, kp, ap}, 8'h00);
        chk("R8 flags cleared", {6'd0, aux_obf, obf}, 8'h00);
        mode = 8'h03;
        tick(2);
        chk("R2 kbd before aux", {6'd0, aux_obf, obf}, 8'h01);
        host_read(d, kp, ap);
        chk("R2 kbd byte", d, 8'h4B);
        chk("R8 kbd pop", {6'd0, kp, ap}, 8'h02);
        tick();
        chk("R4 aux dev flags", {6'd0, aux_obf, obf}, 8'h03);
        host_read(d, kp, ap);
        chk("R2 aux byte", d, 8'hA1);
        chk("R8 aux pop", {6'd0, kp, ap}, 8'h01);
    endtask

    task automatic t_mask();
        logic [7:0] d; logic kp, ap;
        mode = 8'h13;
        post_kbd(8'h1C);
        tick(4);
        chk("R3 kbd masked", {7'd0, obf}, 8'h00);
        mode = 8'h23;
        tick(2);
        chk("R3 kbd unmasked", {7'd0, obf}, 8'h01);
        host_read(d, kp, ap);
        chk("R3 kbd byte", d, 8'h1C);
        post_aux(8'h2D);
        tick(4);
        chk("R3 aux masked", {7'd0, obf}, 8'h00);
        mode = 8'h03;
        tick(2);
        chk("R3 aux unmasked", {6'd0, aux_obf, obf}, 8'h03);
        host_read(d, kp, ap);
    endtask

    task automatic t_irq();
        logic [7:0] d; logic kp, ap;
        post_kbd(8'h77);
        tick(2);
        chk("R5 kbd irq on", {6'd0, irq_kbd, irq_aux}, 8'h02);
        mode = 8'h13; #1;
        chk("R5 kbd irq off by disable", {6'd0, irq_kbd, irq_aux}, 8'h00);
        mode = 8'h02; #1;
        chk("R5 kbd irq off by enable bit", {6'd0, irq_kbd, irq_aux}, 8'h00);
        mode = 8'h03;
        host_read(d, kp, ap);
        post_aux(8'h88);
        tick(2);
        chk("R6 aux irq on", {6'd0, irq_kbd, irq_aux}, 8'h01);
        mode = 8'h01; #1;
        chk("R6 aux irq off", {6'd0, irq_kbd, irq_aux}, 8'h00);
        mode = 8'h03;
        host_read(d, kp, ap);
        chk("R6 irqs low after read", {6'd0, irq_kbd, irq_aux}, 8'h00);
    endtask

    task automatic t_hold_and_overwrite();
        logic [7:0] d; logic kp, ap;
        post_kbd(8'h3E);
        tick(2);
        write_reply(1'b1, 8'h22);
        write_reply(1'b0, 8'h33);
        tick(2);
        chk("R7 still kbd flags", {6'd0, aux_obf, obf}, 8'h01);
        #1;
        chk("R7 held byte", rd_data, 8'h3E);
        host_read(d, kp, ap);
        chk("R7 kbd byte read", d, 8'h3E);
        tick();
        chk("R10 kbd tag served", {6'd0, aux_obf, obf}, 8'h01);
        host_read(d, kp, ap);
        chk("R10 newest reply byte", d, 8'h33);
        tick(3);
        chk("R10 old tag gone", {7'd0, obf}, 8'h00);
    endtask

    task automatic t_read_empty();
        logic [7:0] d; logic kp, ap;
        host_read(d, kp, ap);
        chk("R9 repeat byte", d, 8'h33);
        chk("R9 no pop", {6'd0, kp, ap}, 8'h00);
    endtask

    task automatic t_throttle();
        logic [7:0] d; logic kp, ap;
        logic seen_early, seen;
        throttle_en = 1'b1;
        post_kbd(8'h5A);
        tick(2);
        host_read(d, kp, ap);
        chk("R11 first kbd byte", d, 8'h5A);
        post_kbd(8'h6B);
        seen_early = 1'b0;
        for (int i = 0; i < THR; i++) begin
            tick();
            if (obf) seen_early = 1'b1;
        end
        chk("R11 empty during hold-off", {7'd0, seen_early}, 8'h00);
        seen = 1'b0;
        for (int i = 0; i < 4; i++) begin
            tick();
            if (obf) seen = 1'b1;
        end
        chk("R11 selection resumes", {7'd0, seen}, 8'h01);
        host_read(d, kp, ap);
        chk("R11 second kbd byte", d, 8'h6B);
        // aux reads do not start the hold-off
        tick(THR + 4);
        post_aux(8'h90);
        tick(2);
        host_read(d, kp, ap);
        post_aux(8'h91);
        tick(2);
        chk("R11 aux not throttled", {7'd0, obf}, 8'h01);
        host_read(d, kp, ap);
        // disabled timer
        throttle_en = 1'b0;
        post_kbd(8'h10);
        tick(2);
        host_read(d, kp, ap);
        post_kbd(8'h11);
        tick(2);
        chk("R11 no hold-off when disabled", {7'd0, obf}, 8'h01);
        host_read(d, kp, ap);
        chk("R11 byte when disabled", d, 8'h11);
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        tick(3);
        rst_n = 1'b1;
        tick();
        t_reset();
        t_priority();
        t_mask();
        t_irq();
        t_hold_and_overwrite();
        t_read_empty();
        t_throttle();
        tick(2);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule